// File: doc/BRIEF.md
# Paired DAC Code Register Bank

This block stores the output codes for eight DAC channels (A to H) and two control words. A host writes one word at a time. It gives a 4-bit address, a data word and a write strobe. The address picks how the word is applied:

- Direct load into one channel.
- Load into one of the two control words.
- Broadcast of the same code to all eight channels.
- Paired load. One channel of a fixed pair takes the data, and its partner takes the bitwise complement of the data. This drives two channels in opposite directions with a single write.

All stored values appear in parallel on the outputs. The analog converters downstream read them there. A synchronous reset clears every register to zero.

Channel codes and control words all share one parameterised width. The channel codes leave the block packed into a single vector. Channel A occupies the lowest `CODE_W` bits, then B, and so on up to H.

Top module: `dac_code_bank`

## Requirements
- R1: With `wr_en` high and `wr_addr` in 0000..0111, the channel whose index equals the address (0 = A .. 7 = H) holds `wr_data` after the clock edge. Every other channel and both control words keep their values.
- R2: With `wr_en` high, address 1000 loads `ctrl0` and address 1001 loads `ctrl1` with `wr_data`. No channel code and not the other control word changes.
- R3: With `wr_en` high and address 1010, all eight channels hold `wr_data` after the same clock edge. The control words keep their values.
- R4: With `wr_en` high and address 1011, no register changes.
- R5: With `wr_en` high and address 11pp (pp = 0..3), channel 2·pp holds `wr_data` and channel 2·pp+1 holds the bitwise complement of `wr_data` over `CODE_W` bits. All other channels and both control words keep their values. The pairs are A/B, C/D, E/F and G/H.
- R6: While `wr_en` is low, no register changes, whatever `wr_addr` and `wr_data` carry.
- R7: When `rst` is high at a clock edge, every channel code and both control words are zero after that edge. This holds even if `wr_en` is high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Command address selecting target and write mode |
| wr_data | input | CODE_W | Word to write |
| dac_codes | output | NUM_CH*CODE_W | Stored channel codes, channel A in the lowest bits |
| ctrl0 | output | CODE_W | Control word 0 |
| ctrl1 | output | CODE_W | Control word 1 |

## Verification
The bench drives every address through a directed task per write mode and compares all ten outputs against a bench-side model after each write. The data patterns are chosen to expose specific faults:

- All-ones and all-zeros words expose a pair whose partner was loaded with the data instead of its complement.
- Alternating 0xAAA/0x555 words expose bit swaps and partial inversion.
- A distinct value per channel before each broadcast, pair, reserved or idle write shows whether any channel outside the target was disturbed.
- Reset is applied both alone and together with a live write, which shows that reset takes priority.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

   localparam int unsigned ADDR_W = 4;

   // command codes whose values the decoder depends on
   localparam logic [ADDR_W-1:0] CMD_CTRL0    = 4'b1000;
   localparam logic [ADDR_W-1:0] CMD_CTRL1    = 4'b1001;
   localparam logic [ADDR_W-1:0] CMD_BCAST    = 4'b1010;
   localparam logic [ADDR_W-1:0] CMD_RESERVED = 4'b1011;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_DIRECT,
      OP_CTRL,
      OP_BCAST,
      OP_PAIR
   } wr_op_e;

endpackage

// File: rtl/dac_bank_decode.sv
module dac_bank_decode
   import dac_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
) (
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   output logic [NUM_CH-1:0]    ch_load,
   output logic [NUM_CH-1:0]    ch_invert,
   output logic [1:0]           ctrl_load,
   output wr_op_e               op
);

   localparam int unsigned SEL_W  = $clog2(NUM_CH);
   localparam int unsigned PAIRS  = NUM_CH / 2;
   localparam int unsigned PAIR_W = SEL_W - 1;

   always_comb begin
      op = OP_NONE;
      if (wr_en) begin
         if (!wr_addr[ADDR_W-1])          op = OP_DIRECT;
         else if (wr_addr[ADDR_W-2])      op = OP_PAIR;
         else if (wr_addr == CMD_BCAST)   op = OP_BCAST;
         else if (wr_addr == CMD_CTRL0 ||
                  wr_addr == CMD_CTRL1)   op = OP_CTRL;
         else                             op = OP_NONE;
      end
   end

   always_comb begin
      ch_load   = '0;
      ch_invert = '0;
      ctrl_load = '0;
      unique case (op)
         OP_DIRECT: begin
            for (int i = 0; i < NUM_CH; i++)
               ch_load[i] = (wr_addr[SEL_W-1:0] == SEL_W'(i));
         end
         OP_BCAST: ch_load = '1;
         OP_PAIR: begin
            for (int p = 0; p < PAIRS; p++) begin
               if (wr_addr[PAIR_W-1:0] == PAIR_W'(p)) begin
                  ch_load[2*p]     = 1'b1;
                  ch_load[2*p+1]   = 1'b1;
                  ch_invert[2*p+1] = 1'b1;
               end
            end
         end
         OP_CTRL: begin
            ctrl_load[0] = (wr_addr == CMD_CTRL0);
            ctrl_load[1] = (wr_addr == CMD_CTRL1);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dac_code_slot.sv
module dac_code_slot #(
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              invert,
   input  logic [CODE_W-1:0] din,
   output logic [CODE_W-1:0] q
);

   logic [CODE_W-1:0] nxt;

   assign nxt = invert ? ~din : din;

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= nxt;
   end

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned NUM_CTRL = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_CTRL-1:0]        load,
   input  logic [CODE_W-1:0]          din,
   output logic [NUM_CTRL*CODE_W-1:0] q
);

   for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
      logic [CODE_W-1:0] r;
      always_ff @(posedge clk) begin
         if (rst)          r <= '0;
         else if (load[k]) r <= din;
      end
      assign q[k*CODE_W +: CODE_W] = r;
   end

endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
   import dac_bank_pkg::*;
#(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned NUM_CH = 8
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [3:0]                 wr_addr,
   input  logic [CODE_W-1:0]          wr_data,
   output logic [NUM_CH*CODE_W-1:0]   dac_codes,
   output logic [CODE_W-1:0]          ctrl0,
   output logic [CODE_W-1:0]          ctrl1
);

   localparam int unsigned NUM_CTRL = 2;

   if (NUM_CH != 8) begin : g_bad_ch
      $error("dac_code_bank: the 4-bit command map needs NUM_CH = 8");
   end
   if (CODE_W < 1 || CODE_W > 32) begin : g_bad_w
      $error("dac_code_bank: CODE_W must lie in 1..32");
   end

   logic [NUM_CH-1:0]          ch_load;
   logic [NUM_CH-1:0]          ch_invert;
   logic [NUM_CTRL-1:0]        ctrl_load;
   logic [NUM_CTRL*CODE_W-1:0] ctrl_q;
   wr_op_e                     op;

   dac_bank_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .ch_load   (ch_load),
      .ch_invert (ch_invert),
      .ctrl_load (ctrl_load),
      .op        (op)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dac_code_slot #(.CODE_W(CODE_W)) u_slot (
         .clk    (clk),
         .rst    (rst),
         .load   (ch_load[i]),
         .invert (ch_invert[i]),
         .din    (wr_data),
         .q      (dac_codes[i*CODE_W +: CODE_W])
      );
   end

   dac_ctrl_regs #(.CODE_W(CODE_W), .NUM_CTRL(NUM_CTRL)) u_ctrl (
      .clk  (clk),
      .rst  (rst),
      .load (ctrl_load),
      .din  (wr_data),
      .q    (ctrl_q)
   );

   assign ctrl0 = ctrl_q[0 +: CODE_W];
   assign ctrl1 = ctrl_q[CODE_W +: CODE_W];

endmodule

module dac_code_bank_chk #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned NUM_CH = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     wr_en,
   input logic [3:0]               wr_addr,
   input logic [CODE_W-1:0]        wr_data,
   input logic [NUM_CH*CODE_W-1:0] dac_codes,
   input logic [CODE_W-1:0]        ctrl0,
   input logic [CODE_W-1:0]        ctrl1
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      // R1: addressed channel takes the data
      a_r1_direct_load: assert property (@(posedge clk) disable iff (rst)
         wr_en && wr_addr == 4'(i) |=> dac_codes[i*CODE_W +: CODE_W] == $past(wr_data));
      // R1: other channels hold on a direct write
      a_r1_others_hold: assert property (@(posedge clk) disable iff (rst)
         wr_en && !wr_addr[3] && wr_addr[2:0] != 3'(i) |=> $stable(dac_codes[i*CODE_W +: CODE_W]));
      // R3: broadcast reaches every channel
      a_r3_bcast: assert property (@(posedge clk) disable iff (rst)
         wr_en && wr_addr == 4'b1010 |=> dac_codes[i*CODE_W +: CODE_W] == $past(wr_data));
      // R2: control writes leave channels alone
      a_r2_ch_hold: assert property (@(posedge clk) disable iff (rst)
         wr_en && (wr_addr == 4'b1000 || wr_addr == 4'b1001) |=> $stable(dac_codes[i*CODE_W +: CODE_W]));
   end

   for (genvar p = 0; p < NUM_CH/2; p++) begin : g_p
      // R5: pair gets data and complement
      a_r5_pair_true: assert property (@(posedge clk) disable iff (rst)
         wr_en && wr_addr == 4'(12 + p) |=> dac_codes[2*p*CODE_W +: CODE_W] == $past(wr_data));
      a_r5_pair_comp: assert property (@(posedge clk) disable iff (rst)
         wr_en && wr_addr == 4'(12 + p) |=> dac_codes[(2*p+1)*CODE_W +: CODE_W] == ~$past(wr_data));
   end

   // R2: control word loads
   a_r2_ctrl0: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_addr == 4'b1000 |=> ctrl0 == $past(wr_data) && $stable(ctrl1));
   a_r2_ctrl1: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_addr == 4'b1001 |=> ctrl1 == $past(wr_data) && $stable(ctrl0));
   // R4: reserved code writes nothing
   a_r4_reserved: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_addr == 4'b1011 |=> $stable(dac_codes) && $stable(ctrl0) && $stable(ctrl1));
   // R6: idle strobe holds everything
   a_r6_idle: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(dac_codes) && $stable(ctrl0) && $stable(ctrl1));
   // R7: reset clears all
   a_r7_reset: assert property (@(posedge clk)
      rst |=> dac_codes == '0 && ctrl0 == '0 && ctrl1 == '0);

endmodule

bind dac_code_bank dac_code_bank_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tb_dac_code_bank.sv
module tb_dac_code_bank;

   localparam int CW = 12;
   localparam int NC = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_en = 1'b0;
   logic [3:0]        wr_addr = '0;
   logic [CW-1:0]     wr_data = '0;
   logic [NC*CW-1:0]  dac_codes;
   logic [CW-1:0]     ctrl0, ctrl1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [CW-1:0] m_ch [NC];
   logic [CW-1:0] m_c0, m_c1;

   always #4 clk = ~clk;

   dac_code_bank #(.CODE_W(CW), .NUM_CH(NC)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .dac_codes(dac_codes), .ctrl0(ctrl0), .ctrl1(ctrl1)
   );

   task automatic chk(string req, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      for (int i = 0; i < NC; i++)
         chk(req, $sformatf("channel %0d", i), dac_codes[i*CW +: CW], m_ch[i]);
      chk(req, "ctrl0", ctrl0, m_c0);
      chk(req, "ctrl1", ctrl1, m_c1);
   endtask

   task automatic model_write(logic [3:0] a, logic [CW-1:0] d);
      if (a < 4'd8) m_ch[a] = d;
      else if (a == 4'd8) m_c0 = d;
      else if (a == 4'd9) m_c1 = d;
      else if (a == 4'd10) for (int i = 0; i < NC; i++) m_ch[i] = d;
      else if (a >= 4'd12) begin
         m_ch[2*(a-12)]   = d;
         m_ch[2*(a-12)+1] = ~d;
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NC; i++) m_ch[i] = '0;
      m_c0 = '0;
      m_c1 = '0;
   endtask

   // one write, then compare every output at the following falling edge
   task automatic bus_write(logic [3:0] a, logic [CW-1:0] d, string req);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      model_write(a, d);
      @(negedge clk);
      wr_en = 1'b0;
      chk_all(req);
   endtask

   task automatic seed_distinct(logic [CW-1:0] base, string req);
      for (int i = 0; i < NC; i++) bus_write(4'(i), base + CW'(i * 17), req);
   endtask

   task automatic t_reset(string req);
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b1; wr_addr = 4'd10; wr_data = 12'hFFF;
      @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0; wr_en = 1'b0;
      chk_all(req);
   endtask

   task automatic t_direct();
      seed_distinct(12'h101, "R1");
      bus_write(4'd0, 12'hFFF, "R1");
      bus_write(4'd7, 12'h000, "R1");
      bus_write(4'd3, 12'hAAA, "R1");
      bus_write(4'd4, 12'h555, "R1");
   endtask

   task automatic t_ctrl();
      bus_write(4'd8, 12'hC3C, "R2");
      bus_write(4'd9, 12'h5A5, "R2");
      bus_write(4'd8, 12'h000, "R2");
   endtask

   task automatic t_bcast();
      seed_distinct(12'h222, "R3");
      bus_write(4'd10, 12'h9E7, "R3");
      bus_write(4'd10, 12'hFFF, "R3");
   endtask

   task automatic t_reserved();
      seed_distinct(12'h345, "R4");
      bus_write(4'd8, 12'h0F0, "R4");
      bus_write(4'd11, 12'hFFF, "R4");
      bus_write(4'd11, 12'h000, "R4");
   endtask

   task automatic t_pair();
      seed_distinct(12'h0A0, "R5");
      for (int p = 0; p < 4; p++) bus_write(4'(12 + p), 12'hFFF, "R5");
      for (int p = 0; p < 4; p++) bus_write(4'(12 + p), 12'hAAA ^ CW'(p), "R5");
      bus_write(4'd12, 12'h000, "R5");
   endtask

   task automatic t_idle();
      seed_distinct(12'h777, "R6");
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         wr_en = 1'b0; wr_addr = 4'(a); wr_data = 12'hFFF ^ CW'(a);
      end
      @(negedge clk);
      chk_all("R6");
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk_all("R7");
      t_direct();
      t_ctrl();
      t_bcast();
      t_reserved();
      t_pair();
      t_idle();
      t_reset("R7");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule